// File: doc/BRIEF.md
# Masked-Trigger Circular Acquisition Capture

This block is the capture engine of a small logic-analyzer channel group. A sample clock arrives as an ordinary input. The block oversamples it on the system clock and takes a data word on the edge that `edge_fall` selects. Once a start pulse has armed it, every accepted word is written into a circular acquisition memory.

Each word is compared against a trigger pattern in which every bit is 0, 1 or don't-care. The trigger word is made of several four-bit channel groups placed side by side. Comparison is suppressed until the pre-trigger part of the record has been filled. After the trigger, a fixed number of further words is stored, writing stops and `done` is raised.

The trigger-position setting decides how the record is split between history and aftermath. Software then reads `trig_idx` and dumps the memory through a registered read port. A new start pulse repeats the identical fill-and-stop cycle from location 0.

Top module: `mtcap_capture`

## Requirements
- R1: While reset is asserted, and after it is released until a start pulse, `done` is 0 and `trig_idx` is 0; sample edges without a start pulse do not raise `done`.
- R2: Trigger bit i takes part in the comparison only when `trig_care[i]` is 1, and then requires `smp_data[i] == trig_val[i]`; bits whose `trig_care` bit is 0 are don't-care. The word stored at `trig_idx` satisfies this rule.
- R3: A word can be the trigger only after the pre-trigger depth of earlier words has been written since the start pulse. An all-don't-care pattern in end position therefore triggers on the word at index DEPTH-1.
- R4: After the trigger word, exactly the post-trigger depth of further words is written. On the clock edge that stores the last of them, `done` goes to 1. Later sample edges write nothing until the next start pulse.
- R5: `trig_pos` is latched at start. Value 0 (begin) gives pre = 0 and post = DEPTH-1. Value 2 (end) gives pre = DEPTH-1 and post = 0. Values 1 and 3 (center) give pre = post = DEPTH/2-1.
- R6: With `edge_fall` = 0 a word is taken only on a 0-to-1 change of `samp_clk`. With `edge_fall` = 1 a word is taken only on a 1-to-0 change. One word is taken per selected edge.
- R7: `trig_idx` is the memory location of the trigger word. It holds its value while `done` is 1 until the next start pulse.
- R8: A start pulse clears `done` and restarts writing at location 0. Repeating the same configuration and input stream gives the same `trig_idx` and the same memory contents.
- R9: `rd_data` shows the memory word at the `rd_addr` presented one clock earlier.
- R10: Writes go to consecutive locations and wrap from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| samp_clk | input | 1 | Sample clock level, synchronous to clk |
| edge_fall | input | 1 | 0: rising sample edge, 1: falling sample edge |
| start | input | 1 | One-cycle pulse that starts a new acquisition |
| smp_data | input | GROUPS*GRP_W | Sampled data word |
| trig_val | input | GROUPS*GRP_W | Trigger comparison value |
| trig_care | input | GROUPS*GRP_W | Per-bit compare enable, 0 = don't-care |
| trig_pos | input | 2 | Trigger position: 0 begin, 1/3 center, 2 end |
| rd_addr | input | $clog2(DEPTH) | Memory read address |
| rd_data | output | GROUPS*GRP_W | Memory word, one cycle after rd_addr |
| done | output | 1 | Acquisition finished |
| trig_idx | output | $clog2(DEPTH) | Memory location of the trigger word |

## Verification
The bound checker watches the following on every cycle:
- no write happens while `done` is high;
- a trigger fires only on a word that meets the masked comparison, and only after the pre-trigger fill;
- the write pointer advances by exactly one per write;
- a start pulse clears `done`;
- `trig_idx` and `done` stay put once the record is complete.

The following can only be shown by the bench's scenarios, which mirror the memory and compare a full dump:
- the exact trigger location for each position setting;
- the exact number of post-trigger words;
- that only the selected edge produces a sample;
- that a repeated run leaves identical storage.

// File: rtl/mtcap_pkg.sv
package mtcap_pkg;

  typedef enum logic [1:0] {
    POS_BEGIN  = 2'd0,
    POS_CENTER = 2'd1,
    POS_END    = 2'd2,
    POS_MID2   = 2'd3
  } trig_pos_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;

endpackage

// File: rtl/mtcap_edge_sel.sv
module mtcap_edge_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_clk,
  input  logic edge_fall,
  output logic strobe
);

  logic level_q;
  logic level_d;
  logic rise_seen;
  logic fall_seen;

  always_comb begin
    level_d   = samp_clk;
    rise_seen = samp_clk & ~level_q;
    fall_seen = ~samp_clk & level_q;
    strobe    = edge_fall ? fall_seen : rise_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
    end else begin
      level_q <= level_d;
    end
  end

endmodule

// File: rtl/mtcap_match.sv
module mtcap_match #(
  parameter int GROUPS = 2,
  parameter int GRP_W  = 4,
  localparam int W     = GROUPS * GRP_W
) (
  input  logic [W-1:0] data,
  input  logic [W-1:0] val,
  input  logic [W-1:0] care,
  output logic         hit
);

  logic [GROUPS-1:0] grp_hit;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [GRP_W-1:0] diff;
    always_comb begin
      diff       = (data[g*GRP_W +: GRP_W] ^ val[g*GRP_W +: GRP_W]) & care[g*GRP_W +: GRP_W];
      grp_hit[g] = (diff == '0);
    end
  end

  always_comb hit = &grp_hit;

endmodule

// File: rtl/mtcap_ctrl.sv
module mtcap_ctrl
  import mtcap_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          strobe,
  input  logic          hit,
  input  logic [1:0]    pos_in,
  output logic          wr_en,
  output logic [AW-1:0] wr_ptr,
  output logic          fire,
  output logic          pre_full,
  output logic          done,
  output logic [AW-1:0] trig_idx
);

  localparam logic [AW-1:0] HALF_DEPTH = AW'(DEPTH / 2 - 1);
  localparam logic [AW-1:0] FULL_DEPTH = AW'(DEPTH - 1);

  cap_state_e    state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] tidx_q, tidx_d;
  trig_pos_e     pos_q, pos_d;
  logic [AW-1:0] pre_need;
  logic [AW-1:0] post_need;

  always_comb begin
    case (pos_q)
      POS_BEGIN: begin pre_need = '0;         post_need = FULL_DEPTH; end
      POS_END:   begin pre_need = FULL_DEPTH; post_need = '0;         end
      default:   begin pre_need = HALF_DEPTH; post_need = HALF_DEPTH; end
    endcase
  end

  always_comb begin
    pre_full = (cnt_q == pre_need);
    wr_en    = strobe && !start && ((state_q == ST_PRE) || (state_q == ST_POST));
    fire     = wr_en && (state_q == ST_PRE) && pre_full && hit;
  end

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    cnt_d   = cnt_q;
    tidx_d  = tidx_q;
    pos_d   = pos_q;
    if (start) begin
      state_d = ST_PRE;
      ptr_d   = '0;
      cnt_d   = '0;
      tidx_d  = '0;
      pos_d   = trig_pos_e'(pos_in);
    end else if (wr_en) begin
      ptr_d = ptr_q + 1'b1;
      if (state_q == ST_PRE) begin
        if (fire) begin
          tidx_d  = ptr_q;
          cnt_d   = '0;
          state_d = (post_need == '0) ? ST_DONE : ST_POST;
        end else if (!pre_full) begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == post_need - 1'b1) begin
          state_d = ST_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      cnt_q   <= '0;
      tidx_q  <= '0;
      pos_q   <= POS_CENTER;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      cnt_q   <= cnt_d;
      tidx_q  <= tidx_d;
      pos_q   <= pos_d;
    end
  end

  always_comb begin
    wr_ptr   = ptr_q;
    done     = (state_q == ST_DONE);
    trig_idx = tidx_q;
  end

endmodule

// File: rtl/mtcap_mem.sv
module mtcap_mem #(
  parameter int W     = 8,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] store_q [DEPTH];
  logic [W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) begin
      store_q[waddr] <= wdata;
    end
    rd_q <= store_q[raddr];
  end

  always_comb rdata = rd_q;

endmodule

// File: rtl/mtcap_capture.sv
module mtcap_capture #(
  parameter int  GROUPS = 2,
  parameter int  GRP_W  = 4,
  parameter int  DEPTH  = 2048,
  localparam int W      = GROUPS * GRP_W,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_clk,
  input  logic          edge_fall,
  input  logic          start,
  input  logic [W-1:0]  smp_data,
  input  logic [W-1:0]  trig_val,
  input  logic [W-1:0]  trig_care,
  input  logic [1:0]    trig_pos,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          done,
  output logic [AW-1:0] trig_idx
);

  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic          strobe;
  logic          hit;
  logic          wr_en;
  logic [AW-1:0] wr_ptr;
  logic          fire;
  logic          pre_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  always_comb rst_sync_n = rs_q[1];

  mtcap_edge_sel u_edge (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .samp_clk  (samp_clk),
    .edge_fall (edge_fall),
    .strobe    (strobe)
  );

  mtcap_match #(.GROUPS(GROUPS), .GRP_W(GRP_W)) u_match (
    .data (smp_data),
    .val  (trig_val),
    .care (trig_care),
    .hit  (hit)
  );

  mtcap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .strobe   (strobe),
    .hit      (hit),
    .pos_in   (trig_pos),
    .wr_en    (wr_en),
    .wr_ptr   (wr_ptr),
    .fire     (fire),
    .pre_full (pre_full),
    .done     (done),
    .trig_idx (trig_idx)
  );

  mtcap_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_ptr),
    .wdata (smp_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/mtcap_capture_chk.sv
module mtcap_capture_chk #(
  parameter int W  = 8,
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [W-1:0]  smp_data,
  input logic [W-1:0]  trig_val,
  input logic [W-1:0]  trig_care,
  input logic          wr_en,
  input logic [AW-1:0] wr_ptr,
  input logic          fire,
  input logic          pre_full,
  input logic          done,
  input logic [AW-1:0] trig_idx
);

  a_r4_no_write_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  a_r4_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_en));

  a_r2_fire_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (((smp_data ^ trig_val) & trig_care) == '0));

  a_r3_fire_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> pre_full);

  a_r10_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !start) |=> (wr_ptr == $past(wr_ptr) + 1'b1));

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && (wr_ptr == '0)));

  a_r7_idx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(trig_idx)));

endmodule

bind mtcap_capture mtcap_capture_chk #(.W(W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .smp_data  (smp_data),
  .trig_val  (trig_val),
  .trig_care (trig_care),
  .wr_en     (wr_en),
  .wr_ptr    (wr_ptr),
  .fire      (fire),
  .pre_full  (pre_full),
  .done      (done),
  .trig_idx  (trig_idx)
);

// File: tb/mtcap_capture_tb_top.sv
`timescale 1ns/1ps
module mtcap_capture_tb_top;

  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int W     = 8;
  localparam int NVEC  = 8;

  typedef struct packed {
    logic [7:0] val;
    logic [7:0] care;
    logic [1:0] pos;
    logic       fall;
    logic [7:0] seed;
    logic [7:0] step;
  } vec_t;

  // val, care, pos, fall, seed, step
  localparam vec_t VECS [NVEC] = '{
    '{8'h11, 8'h11, 2'd1, 1'b0, 8'h00, 8'h01},
    '{8'h22, 8'h22, 2'd0, 1'b1, 8'h10, 8'h01},
    '{8'h44, 8'h44, 2'd2, 1'b0, 8'h03, 8'h03},
    '{8'h88, 8'h88, 2'd3, 1'b1, 8'h00, 8'h05},
    '{8'h00, 8'hFF, 2'd1, 1'b0, 8'h01, 8'h01},
    '{8'h11, 8'h11, 2'd1, 1'b0, 8'h00, 8'h01},
    '{8'h0F, 8'h00, 2'd0, 1'b0, 8'h20, 8'h07},
    '{8'hA5, 8'h00, 2'd2, 1'b1, 8'h40, 8'h02}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          samp_clk;
  logic          edge_fall;
  logic          start;
  logic [W-1:0]  smp_data;
  logic [W-1:0]  trig_val;
  logic [W-1:0]  trig_care;
  logic [1:0]    trig_pos;
  logic [AW-1:0] rd_addr;
  logic [W-1:0]  rd_data;
  logic          done;
  logic [AW-1:0] trig_idx;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  logic [W-1:0] mirror [DEPTH];
  bit           valid  [DEPTH];
  int           first_tidx;

  always #2 clk = ~clk;

  mtcap_capture #(.GROUPS(2), .GRP_W(4), .DEPTH(DEPTH)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_clk  (samp_clk),
    .edge_fall (edge_fall),
    .start     (start),
    .smp_data  (smp_data),
    .trig_val  (trig_val),
    .trig_care (trig_care),
    .trig_pos  (trig_pos),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .done      (done),
    .trig_idx  (trig_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sample(input logic [W-1:0] d);
    @(negedge clk);
    smp_data = d;
    samp_clk = ~samp_clk;
    @(negedge clk);
    samp_clk = ~samp_clk;
  endtask

  task automatic read_mem(input int a, output logic [W-1:0] v);
    @(negedge clk);
    rd_addr = AW'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  function automatic int pre_of(input logic [1:0] p);
    if (p == 2'd0) return 0;
    if (p == 2'd2) return DEPTH - 1;
    return DEPTH / 2 - 1;
  endfunction

  function automatic int post_of(input logic [1:0] p);
    if (p == 2'd0) return DEPTH - 1;
    if (p == 2'd2) return 0;
    return DEPTH / 2 - 1;
  endfunction

  task automatic run_vec(input int vi);
    vec_t v;
    int ptr, cnt, st, tidx, pre, post, k;
    bit early;
    logic [W-1:0] d, rv;
    bit dump_ok;
    int bad_addr, bad_act, bad_exp;
    v = VECS[vi];
    @(negedge clk);
    edge_fall = v.fall;
    trig_val  = v.val;
    trig_care = v.care;
    trig_pos  = v.pos;
    @(negedge clk);
    samp_clk = v.fall;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pre = pre_of(v.pos);
    post = post_of(v.pos);
    ptr = 0; cnt = 0; st = 0; tidx = 0; early = 0; k = 0;
    while (st != 2 && k < 2000) begin
      if (done) early = 1;
      d = v.seed + W'(k) * v.step;
      sample(d);
      mirror[ptr] = d;
      valid[ptr]  = 1;
      if (st == 0) begin
        if (cnt == pre && (((d ^ v.val) & v.care) == 0)) begin
          tidx = ptr; cnt = 0;
          st = (post == 0) ? 2 : 1;
        end else if (cnt < pre) begin
          cnt++;
        end
      end else begin
        if (cnt == post - 1) st = 2;
        else cnt++;
      end
      ptr = (ptr + 1) % DEPTH;
      k++;
    end
    check(!early, $sformatf("R4 done before last post sample, vec %0d", vi), early, 0);
    check(done === 1'b1, $sformatf("R4/R5 done after post count, vec %0d", vi), done, 1);
    check(trig_idx === AW'(tidx), $sformatf("R3/R5/R7 trig_idx, vec %0d", vi), trig_idx, tidx);
    if (vi == 0) first_tidx = tidx;
    if (vi == 5) check(trig_idx === AW'(first_tidx), "R8 repeated run trig_idx", trig_idx, first_tidx);
    // extra edges after done must not write (R4)
    for (int e = 0; e < 3; e++) sample(8'hE0 + W'(e));
    check(done === 1'b1, $sformatf("R4 done held after extra edges, vec %0d", vi), done, 1);
    read_mem(tidx, rv);
    check((((rv ^ v.val) & v.care) == 0) && (rv === mirror[tidx]),
          $sformatf("R2/R7 trigger word matches pattern, vec %0d", vi), rv, mirror[tidx]);
    dump_ok = 1; bad_addr = 0; bad_act = 0; bad_exp = 0;
    for (int a = 0; a < DEPTH; a++) begin
      read_mem(a, rv);
      if (valid[a] && rv !== mirror[a] && dump_ok) begin
        dump_ok = 0; bad_addr = a; bad_act = rv; bad_exp = mirror[a];
      end
    end
    check(dump_ok, $sformatf("R4/R6/R8/R9/R10 memory dump vec %0d addr %0d", vi, bad_addr),
          bad_act, bad_exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; samp_clk = 1'b0; edge_fall = 1'b0; start = 1'b0;
    smp_data = '0; trig_val = '0; trig_care = '0; trig_pos = 2'd1; rd_addr = '0;
    for (int a = 0; a < DEPTH; a++) valid[a] = 0;
    repeat (3) @(negedge clk);
    check(done === 1'b0, "R1 done in reset", done, 0);
    check(trig_idx === '0, "R1 trig_idx in reset", trig_idx, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // edges with no start pulse
    trig_care = '0;
    for (int i = 0; i < 4; i++) sample(W'(i));
    check(done === 1'b0, "R1 no done without start", done, 0);
    check(trig_idx === '0, "R1 trig_idx idle", trig_idx, 0);

    for (int vi = 0; vi < NVEC; vi++) run_vec(vi);

    // R8 start clears done
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done === 1'b0, "R8 start clears done", done, 0);
    // reset during an acquisition (R1)
    edge_fall = 1'b0; samp_clk = 1'b0; trig_care = '0; trig_pos = 2'd2;
    for (int i = 0; i < 5; i++) sample(W'(i));
    rst_n = 1'b0;
    @(negedge clk);
    check(done === 1'b0, "R1 reset mid-run done", done, 0);
    check(trig_idx === '0, "R1 reset mid-run trig_idx", trig_idx, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < DEPTH + 2; i++) sample(W'(i));
    check(done === 1'b0, "R1 edges after reset ignored", done, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule